// File: doc/BRIEF.md
# PCI read command selector

This block sits in the DMA read path of a PCI bus master. For each read request it gets the start address, the byte count and the cache configuration. One clock later it returns the PCI read command the master should issue (Memory Read, Memory Read Line or Memory Read Multiple), the burst length in Dwords, and a flag that says whether the address needs a dual address cycle. It does not drive the PCI bus and does not move any data.

The decision depends on four things:

- the cache enable bit and the two per-command enable bits;
- whether the cache line size register holds a usable value;
- how the transfer lies against Dword and cache line boundaries;
- whether the request is an opcode fetch from a region that must not be prefetched.

When a transfer qualifies for both Read Multiple and Read Line, Read Multiple takes priority.

The decision is held in a register. It updates only when a request is strobed and stays in place until the next strobe.

Top module: `pci_rdcmd_sel`

## Requirements
- R1: After reset, `vld_o`, `cmd_o`, `burst_o` and `dac_o` are all zero. `vld_o` is high for exactly one cycle, in the cycle after `req_vld` is high. `cmd_o`, `burst_o` and `dac_o` change only in that cycle and keep their values while no request is strobed, even if the request inputs change.
- R2: `dac_o` is 1 when bits 63..32 of the request address are not all zero, and 0 otherwise.
- R3: When `cache_en` is 0, the command is always Memory Read (4'b0110).
- R4: The cache line size `cls_dw` (in Dwords) is usable only if it is one of 2, 4, 8, 16, 32, 64 or 128 and is no larger than the burst limit. Any other value gives the same result as `cache_en` = 0.
- R5: The command is Memory Read Line (4'b1110) when all of the following hold and R6 does not apply:
  - `cache_en` and `rdline_en` are both 1;
  - the line size is usable;
  - `nopf_fetch` is 0;
  - the bytes touched span at least two Dwords and all lie inside one cache line.

  The burst is then the number of Dwords touched.
- R6: The command is Memory Read Multiple (4'b1100) when all of the following hold:
  - `cache_en` and `rdmult_en` are both 1;
  - the line size is usable;
  - `nopf_fetch` is 0;
  - the address is aligned to a cache line (`cls_dw`*4 bytes);
  - the byte count is at least one line.

  The burst is the largest multiple of `cls_dw` whose byte size is at most the byte count and that is at most the burst limit. R6 takes priority over R5.
- R7: When `nopf_fetch` is 1, the command is Memory Read, whatever the other inputs are.
- R8: In every other case the command is Memory Read. Its burst is the number of Dwords touched, ceil((addr[1:0] + bytes) / 4), capped at the burst limit. A byte count of 0 gives a burst of 0.
- R9: The burst limit is 2^`burst_sel` Dwords (1 to 128). No burst exceeds it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Strobe that samples one read request |
| req_addr | input | 64 | Byte start address |
| req_bytes | input | 16 | Transfer length in bytes |
| cls_dw | input | 8 | Cache line size in Dwords |
| burst_sel | input | 3 | Log2 of the burst limit in Dwords |
| cache_en | input | 1 | Cache mode enable |
| rdline_en | input | 1 | Allows Memory Read Line |
| rdmult_en | input | 1 | Allows Memory Read Multiple |
| nopf_fetch | input | 1 | Opcode fetch from a non-prefetchable region |
| vld_o | output | 1 | One-cycle pulse: a new decision is on the outputs |
| cmd_o | output | 4 | PCI read command code |
| burst_o | output | 8 | Burst length in Dwords |
| dac_o | output | 1 | A dual address cycle is needed |

## Verification
Every result (command, burst, DAC flag and the valid pulse) is due exactly one rising edge after the cycle in which `req_vld` is high.

The bench drives each request on a falling edge and compares the outputs on the next falling edge, halfway between registering edges.

It then scrambles all request inputs with `req_vld` low and checks on the following falling edge that the pulse has dropped and the decision has not moved.

// File: rtl/pci_rdcmd_pkg.sv
package pci_rdcmd_pkg;

  localparam int CLS_W      = 8;
  localparam int LG_W       = 3;
  localparam int BURST_W    = 8;
  localparam int LINE_OFF_W = 2 + (1 << LG_W) - 1;

  localparam logic [3:0] CMD_MEM_RD  = 4'b0110;
  localparam logic [3:0] CMD_RD_LINE = 4'b1110;
  localparam logic [3:0] CMD_RD_MULT = 4'b1100;

  // True for a power of two in 2..128
  function automatic logic cls_is_legal(input logic [CLS_W-1:0] c);
    return (c > CLS_W'(1)) && ((c & (c - CLS_W'(1))) == '0);
  endfunction

  // Index of the highest set bit (0 when none)
  function automatic logic [LG_W-1:0] cls_log2(input logic [CLS_W-1:0] c);
    logic [LG_W-1:0] r;
    r = '0;
    for (int i = 0; i < CLS_W; i++) begin
      if (c[i]) r = LG_W'(i);
    end
    return r;
  endfunction

  // Burst limit in Dwords from its log2 code
  function automatic logic [BURST_W-1:0] burst_limit(input logic [LG_W-1:0] s);
    return BURST_W'(1) << s;
  endfunction

endpackage

// File: rtl/rdcmd_span.sv
module rdcmd_span
  import pci_rdcmd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LINE_OFF_W-1:0] addr_lo,
  input  logic [CNT_W-1:0]      nbytes,
  input  logic [LG_W-1:0]       cls_lg,
  output logic [CNT_W-1:0]      dw_cnt,
  output logic                  crosses_dw,
  output logic                  crosses_line,
  output logic                  line_aligned,
  output logic [CNT_W-1:0]      full_lines
);

  localparam int LB_W  = LINE_OFF_W + 1;
  localparam int SUM_W = CNT_W + 2;

  logic [LB_W-1:0]  line_bytes;
  logic [LB_W-1:0]  line_off;
  logic [SUM_W-1:0] dw_sum;
  logic [SUM_W-1:0] dw_round;
  logic [SUM_W-1:0] line_end;

  assign line_bytes   = LB_W'(4) << cls_lg;
  assign line_off     = {1'b0, addr_lo} & (line_bytes - LB_W'(1));
  assign dw_sum       = SUM_W'(addr_lo[1:0]) + SUM_W'(nbytes);
  assign dw_round     = dw_sum + SUM_W'(3);
  assign line_end     = SUM_W'(line_off) + SUM_W'(nbytes);

  assign crosses_dw   = dw_sum > SUM_W'(4);
  assign crosses_line = line_end > SUM_W'(line_bytes);
  assign line_aligned = (line_off == '0);
  assign full_lines   = nbytes >> (32'(cls_lg) + 2);
  assign dw_cnt       = (nbytes == '0) ? '0 : dw_round[SUM_W-1:2];

  // R5
  span_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crosses_line |-> crosses_dw);

endmodule

// File: rtl/rdcmd_policy.sv
module rdcmd_policy
  import pci_rdcmd_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cache_en,
  input  logic               rdline_en,
  input  logic               rdmult_en,
  input  logic               nopf_fetch,
  input  logic [CLS_W-1:0]   cls_dw,
  input  logic [LG_W-1:0]    cls_lg,
  input  logic [LG_W-1:0]    burst_sel,
  input  logic [CNT_W-1:0]   dw_cnt,
  input  logic               crosses_dw,
  input  logic               crosses_line,
  input  logic               line_aligned,
  input  logic [CNT_W-1:0]   full_lines,
  output logic [3:0]         sel_cmd,
  output logic [BURST_W-1:0] sel_burst
);

  logic [BURST_W-1:0] limit;
  logic [BURST_W-1:0] lines_cap;
  logic [BURST_W-1:0] rm_lines;
  logic [BURST_W-1:0] rm_burst;
  logic [BURST_W-1:0] mr_burst;
  logic               cls_ok;
  logic               gate_ok;
  logic               rm_hit;
  logic               rl_hit;

  assign limit     = burst_limit(burst_sel);
  assign cls_ok    = cache_en && cls_is_legal(cls_dw) && (BURST_W'(cls_dw) <= limit);
  assign gate_ok   = cls_ok && !nopf_fetch;
  assign rm_hit    = gate_ok && rdmult_en && line_aligned && (full_lines != '0);
  assign rl_hit    = gate_ok && rdline_en && crosses_dw && !crosses_line;

  assign lines_cap = limit >> cls_lg;
  assign rm_lines  = (full_lines > CNT_W'(lines_cap)) ? lines_cap : BURST_W'(full_lines);
  assign rm_burst  = rm_lines << cls_lg;
  assign mr_burst  = (dw_cnt > CNT_W'(limit)) ? limit : BURST_W'(dw_cnt);

  always_comb begin
    if (rm_hit) begin
      sel_cmd   = CMD_RD_MULT;
      sel_burst = rm_burst;
    end else if (rl_hit) begin
      sel_cmd   = CMD_RD_LINE;
      sel_burst = BURST_W'(dw_cnt);
    end else begin
      sel_cmd   = CMD_MEM_RD;
      sel_burst = mr_burst;
    end
  end

  // R7
  nopf_mr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nopf_fetch |-> (sel_cmd == CMD_MEM_RD));

  // R3
  cache_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cache_en |-> (sel_cmd == CMD_MEM_RD));

  // R6
  rm_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_cmd == CMD_RD_MULT) |->
      ((sel_burst <= limit) && (sel_burst != '0) &&
       ((sel_burst & (BURST_W'(cls_dw) - BURST_W'(1))) == '0)));

  // R5
  rl_inline_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_cmd == CMD_RD_LINE) |-> (crosses_dw && !crosses_line));

  // R9
  burst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_burst <= limit);

endmodule

// File: rtl/rdcmd_outreg.sv
module rdcmd_outreg
  import pci_rdcmd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [3:0]         cmd_d,
  input  logic [BURST_W-1:0] burst_d,
  input  logic               dac_d,
  output logic               vld_q,
  output logic [3:0]         cmd_q,
  output logic [BURST_W-1:0] burst_q,
  output logic               dac_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      cmd_q   <= '0;
      burst_q <= '0;
      dac_q   <= 1'b0;
    end else begin
      vld_q <= load;
      if (load) begin
        cmd_q   <= cmd_d;
        burst_q <= burst_d;
        dac_q   <= dac_d;
      end
    end
  end

  // R1
  pulse_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> vld_q);

  // R1
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(load));

  // R1
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(cmd_q) && $stable(burst_q) && $stable(dac_q)));

endmodule

// File: rtl/pci_rdcmd_sel.sv
module pci_rdcmd_sel
  import pci_rdcmd_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int CNT_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_vld,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [CNT_W-1:0]   req_bytes,
  input  logic [CLS_W-1:0]   cls_dw,
  input  logic [LG_W-1:0]    burst_sel,
  input  logic               cache_en,
  input  logic               rdline_en,
  input  logic               rdmult_en,
  input  logic               nopf_fetch,
  output logic               vld_o,
  output logic [3:0]         cmd_o,
  output logic [BURST_W-1:0] burst_o,
  output logic               dac_o
);

  localparam int HI_LSB = 32;

  logic [LG_W-1:0]    cls_lg;
  logic [CNT_W-1:0]   dw_cnt;
  logic               crosses_dw;
  logic               crosses_line;
  logic               line_aligned;
  logic [CNT_W-1:0]   full_lines;
  logic [3:0]         sel_cmd;
  logic [BURST_W-1:0] sel_burst;
  logic               dac_need;
  logic               unused_mid_addr;

  assign cls_lg          = cls_log2(cls_dw);
  assign dac_need        = |req_addr[ADDR_W-1:HI_LSB];
  assign unused_mid_addr = ^req_addr[HI_LSB-1:LINE_OFF_W];

  rdcmd_span #(.CNT_W(CNT_W)) span_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_lo      (req_addr[LINE_OFF_W-1:0]),
    .nbytes       (req_bytes),
    .cls_lg       (cls_lg),
    .dw_cnt       (dw_cnt),
    .crosses_dw   (crosses_dw),
    .crosses_line (crosses_line),
    .line_aligned (line_aligned),
    .full_lines   (full_lines)
  );

  rdcmd_policy #(.CNT_W(CNT_W)) policy_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cache_en     (cache_en),
    .rdline_en    (rdline_en),
    .rdmult_en    (rdmult_en),
    .nopf_fetch   (nopf_fetch),
    .cls_dw       (cls_dw),
    .cls_lg       (cls_lg),
    .burst_sel    (burst_sel),
    .dw_cnt       (dw_cnt),
    .crosses_dw   (crosses_dw),
    .crosses_line (crosses_line),
    .line_aligned (line_aligned),
    .full_lines   (full_lines),
    .sel_cmd      (sel_cmd),
    .sel_burst    (sel_burst)
  );

  rdcmd_outreg out_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (req_vld),
    .cmd_d   (sel_cmd),
    .burst_d (sel_burst),
    .dac_d   (dac_need),
    .vld_q   (vld_o),
    .cmd_q   (cmd_o),
    .burst_q (burst_o),
    .dac_q   (dac_o)
  );

  // R2
  dac_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> (dac_o == $past(|req_addr[ADDR_W-1:HI_LSB])));

endmodule

// File: tb/pci_rdcmd_sel_tb.sv
module pci_rdcmd_sel_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_vld = 1'b0;
  logic [63:0] req_addr = '0;
  logic [15:0] req_bytes = '0;
  logic [7:0]  cls_dw = '0;
  logic [2:0]  burst_sel = '0;
  logic        cache_en = 1'b0;
  logic        rdline_en = 1'b0;
  logic        rdmult_en = 1'b0;
  logic        nopf_fetch = 1'b0;
  logic        vld_o;
  logic [3:0]  cmd_o;
  logic [7:0]  burst_o;
  logic        dac_o;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  always #2.5ns clk = ~clk;

  pci_rdcmd_sel dut_i (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_addr(req_addr),
    .req_bytes(req_bytes), .cls_dw(cls_dw), .burst_sel(burst_sel),
    .cache_en(cache_en), .rdline_en(rdline_en), .rdmult_en(rdmult_en),
    .nopf_fetch(nopf_fetch), .vld_o(vld_o), .cmd_o(cmd_o),
    .burst_o(burst_o), .dac_o(dac_o)
  );

  task automatic check(input string rq, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // Independent restatement of the command rules
  function automatic void ref_calc(input logic [63:0] a, input int n, input int cls,
                                   input int sel, input bit ce, input bit rle,
                                   input bit rme, input bit nopf,
                                   output int cmd, output int burst);
    int limit, lg, ndw, line_b;
    bit legal, ok;
    logic [63:0] last;
    limit  = 1 << sel;
    legal  = (cls == 2) || (cls == 4) || (cls == 8) || (cls == 16) ||
             (cls == 32) || (cls == 64) || (cls == 128);
    ok     = ce && legal && (cls <= limit) && !nopf;
    lg     = 0;
    for (int i = 0; i < 8; i++) if (cls == (1 << i)) lg = i;
    line_b = cls * 4;
    last   = a + 64'(n) - 64'd1;
    ndw    = (n == 0) ? 0 : int'((last >> 2) - (a >> 2)) + 1;
    if (ok && rme && ((a & 64'(line_b - 1)) == 0) && (n >= line_b)) begin
      cmd = 'b1100;
      burst = cls;
      for (int m = limit; m >= cls; m -= cls) begin
        if (m * 4 <= n) begin
          burst = m;
          break;
        end
      end
    end else if (ok && rle && (ndw >= 2) && ((a >> (2 + lg)) == (last >> (2 + lg)))) begin
      cmd = 'b1110;
      burst = ndw;
    end else begin
      cmd = 'b0110;
      burst = (ndw > limit) ? limit : ndw;
    end
  endfunction

  task automatic do_req(input string rq, input logic [63:0] a, input int n, input int cls,
                        input int sel, input bit ce, input bit rle, input bit rme,
                        input bit nopf);
    int ecmd, eburst, edac;
    ref_calc(a, n, cls, sel, ce, rle, rme, nopf, ecmd, eburst);
    edac = (a[63:32] != 0) ? 1 : 0;
    req_addr = a; req_bytes = 16'(n); cls_dw = 8'(cls); burst_sel = 3'(sel);
    cache_en = ce; rdline_en = rle; rdmult_en = rme; nopf_fetch = nopf;
    req_vld = 1'b1;
    @(negedge clk);
    req_vld = 1'b0;
    check("R1", "vld pulse", int'(vld_o), 1);
    check(rq, "cmd", int'(cmd_o), ecmd);
    check(rq, "burst", int'(burst_o), eburst);
    check("R2", "dac", int'(dac_o), edac);
    // scramble inputs without a strobe
    req_addr = {$urandom, $urandom}; req_bytes = 16'($urandom);
    cls_dw = 8'($urandom); burst_sel = 3'($urandom);
    {cache_en, rdline_en, rdmult_en, nopf_fetch} = 4'($urandom);
    @(negedge clk);
    check("R1", "vld idle", int'(vld_o), 0);
    check("R1", "cmd held", int'(cmd_o), ecmd);
    check("R1", "burst held", int'(burst_o), eburst);
    check("R1", "dac held", int'(dac_o), edac);
  endtask

  initial begin
    int seed_v;
    seed_v = int'($urandom(32'h1A2B3C4D));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "reset vld", int'(vld_o), 0);
    check("R1", "reset cmd", int'(cmd_o), 0);
    check("R1", "reset burst", int'(burst_o), 0);
    check("R1", "reset dac", int'(dac_o), 0);

    do_req("R3", 64'h1004, 8, 8, 4, 0, 1, 1, 0);
    do_req("R4", 64'h1004, 8, 3, 4, 1, 1, 1, 0);
    do_req("R4", 64'h1000, 256, 64, 5, 1, 1, 1, 0);
    do_req("R5", 64'h1004, 8, 8, 4, 1, 1, 0, 0);
    do_req("R5", 64'h101C, 8, 8, 4, 1, 1, 0, 0);
    do_req("R6", 64'h1000, 32, 8, 4, 1, 1, 1, 0);
    do_req("R6", 64'h2000, 1000, 4, 5, 1, 0, 1, 0);
    do_req("R6", 64'h3000, 100, 8, 7, 1, 0, 1, 0);
    do_req("R6", 64'h1004, 200, 8, 7, 1, 0, 1, 0);
    do_req("R7", 64'h1000, 32, 8, 4, 1, 1, 1, 1);
    do_req("R8", 64'h1000, 0, 8, 4, 1, 1, 1, 0);
    do_req("R8", 64'h1003, 1, 8, 4, 1, 1, 1, 0);
    do_req("R9", 64'h1001, 400, 8, 2, 0, 0, 0, 0);
    do_req("R2", 64'h0000_0001_0000_1000, 16, 4, 3, 1, 1, 1, 0);

    for (int k = 0; k < 400; k++) begin
      logic [63:0] a;
      int n, cls, r;
      a = {$urandom, $urandom};
      if ($urandom % 3 != 0) a[63:32] = '0;
      if ($urandom % 3 == 0) a[8:0] = '0;
      r = int'($urandom % 10);
      if (r < 7) cls = 2 << r;
      else if (r == 7) cls = int'($urandom % 256);
      else if (r == 8) cls = 3;
      else cls = 1;
      n = ($urandom % 8 == 0) ? int'($urandom % 65536) : int'($urandom % 700);
      do_req("R8", a, n, cls, int'($urandom % 8), ($urandom % 4) != 0,
             1'($urandom), 1'($urandom), ($urandom % 6) == 0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule